// File: doc/BRIEF.md
# Hardware-Software Call Dispatch Controller

This block sequences function calls among a host processor and a small set of hardware function units. Each unit has an ID from 1 to `NUM_UNITS`, and ID 0 stands for the processor. At any moment exactly one party owns execution: either one unit, or the processor.

The owner issues a call with a target. The controller then saves the caller's ID on an internal return stack, loads that ID into the link register and hands execution to the target. When the target signals finish, the controller pops the stack and resumes the saved caller.

A hand-off to the processor raises an interrupt. The interrupt carries a cause bit that tells the processor which case applies:
- a hardware callee that software started has completed;
- hardware is asking for a software routine, and the interrupt carries that routine's ID.

Calls and returns between units need no processor involvement. Any unit may call itself.

A shared register set sits beside the dispatcher. It holds four argument registers, a stack pointer and a return value, all written through one write port. The link register is loaded only by the dispatcher.

Top module: `hcd_ctrl`

## Requirements
- R1: After reset, all unit enables, the interrupt, the interrupt cause, the error flag, the link register and all shared registers are 0, and the processor owns execution.
- R2: When the processor owns execution and raises `cpu_call` with a target ID from 1 to `NUM_UNITS`:
  - in the next cycle, only `unit_en` bit (ID-1) is high;
  - in the same cycle, `link_id` reads 0.
- R3: At most one bit of `unit_en` is high at any time. Call or finish requests from a unit that does not own execution change nothing.
- R4: When a unit finishes and the saved caller is the processor:
  - in the next cycle, all enables are low, `irq` is 1 and `irq_swcall` is 0;
  - `irq_ack` then clears `irq`.
- R5: When the owning unit raises its call with its `unit_to_sw` bit set, in the next cycle:
  - all enables are low;
  - `irq` is 1 and `irq_swcall` is 1;
  - `irq_swid` equals the unit's target field;
  - `link_id` equals the calling unit's ID.
- R6: When the processor owns execution after a software call and raises `cpu_done`, the suspended unit's enable is high in the next cycle.
- R7: When one unit calls another unit:
  - the callee's enable replaces the caller's in the next cycle, and `link_id` holds the caller's ID;
  - when the callee finishes, the caller's enable returns in the next cycle, with no interrupt.
- R8: A unit that calls itself stays enabled. Each finish pops one level, so two finishes are needed before control returns to the original caller.
- R9: Register writes store `reg_wdata` by select code:
  - codes 0 to 3 go to argument registers 0 to 3, which appear on `arg_q` at bits [32k+31:32k];
  - code 4 goes to `sp_q`;
  - code 5 goes to `rv_q`;
  - codes 6 and 7 change nothing.
- R10: A call made while the return stack already holds `DEPTH` entries is dropped: the enables stay unchanged and `err` becomes 1. `err` stays 1 until reset.
- R11: The following are dropped and set `err`, leaving the enables unchanged:
  - a finish or `cpu_done` when the return stack is empty;
  - a hardware call whose target is 0 or greater than `NUM_UNITS`.
- R12: While a unit owns execution, `cpu_call` and `cpu_done` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_call | input | 1 | Processor call request |
| cpu_tgt | input | TGT_W | Target unit ID for a processor call |
| cpu_done | input | 1 | Processor signals that a software callee has returned |
| irq_ack | input | 1 | Clears the interrupt |
| reg_we | input | 1 | Shared register write strobe |
| reg_sel | input | 3 | Shared register select code |
| reg_wdata | input | DATA_W | Shared register write data |
| unit_call | input | NUM_UNITS | Per-unit call request |
| unit_to_sw | input | NUM_UNITS | Per-unit flag: the call targets a software routine |
| unit_tgt | input | NUM_UNITS*TGT_W | Per-unit target field (unit k at bits [k*TGT_W +: TGT_W]) |
| unit_finish | input | NUM_UNITS | Per-unit finish pulse |
| unit_en | output | NUM_UNITS | One-hot unit enables |
| irq | output | 1 | Interrupt to the processor |
| irq_swcall | output | 1 | Cause: 1 means software routine requested, 0 means hardware callee finished |
| irq_swid | output | TGT_W | Requested software routine ID |
| link_id | output | ID_W | Caller ID of the most recent call |
| arg_q | output | 4*DATA_W | Argument registers 0 to 3 |
| sp_q | output | DATA_W | Stack pointer register |
| rv_q | output | DATA_W | Return value register |
| err | output | 1 | Sticky error flag for stack overflow, stack underflow or bad target |

## Verification
The bench targets the following corner cases. Each names the failure it would expose.
- **Self-call.** A design that treats a self-call as a no-op, or that pops twice per finish, drops the enable too early or hands control back to the processor too soon.
- **Stack exactly full.** The return stack is filled to exactly `DEPTH` and one more call is attempted. A design with an off-by-one full test either accepts the extra call, moving the enable, or loses an entry and unwinds to the wrong unit.
- **Foreign requests.** A design that leaks requests from non-owners shows two enables, or an enable jumping to the wrong unit.
- **Mode-specific requests.** A processor call or done during hardware ownership must be ignored, and so must a write to an unused register code. A design that decodes these wrongly shows the resulting changes.
- **Empty-stack return and invalid target.** A design that mishandles these moves an enable instead of raising the error.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int REG_SLOTS = 6;
  localparam int SLOT_SP   = 4;
  localparam int SLOT_RV   = 5;
endpackage

// File: rtl/hcd_lifo.sv
module hcd_lifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [PW-1:0] rd_ptr;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign rd_ptr = PW'(cnt - 1'b1);
  assign top    = empty ? '0 : mem[rd_ptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (push && !full)  cnt <= cnt + 1'b1;
    else if (pop && !empty)  cnt <= cnt - 1'b1;
  end

  // R10
  lifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R11
  lifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R3
  lifo_single_op_chk: assert property (@(posedge clk) disable iff (rst) !(push && pop));
endmodule

// File: rtl/hcd_req_sel.sv
module hcd_req_sel #(
  parameter int N     = 3,
  parameter int TGT_W = 4,
  parameter int ID_W  = 2
) (
  input  logic [ID_W-1:0]    active,
  input  logic [N-1:0]       call,
  input  logic [N-1:0]       to_sw,
  input  logic [N-1:0]       fin,
  input  logic [N*TGT_W-1:0] tgt,
  output logic               s_call,
  output logic               s_sw,
  output logic               s_fin,
  output logic [TGT_W-1:0]   s_tgt
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = (active == ID_W'(g + 1));
  end

  always_comb begin
    s_call = |(hit & call);
    s_sw   = |(hit & to_sw);
    s_fin  = |(hit & fin);
    s_tgt  = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) s_tgt = s_tgt | tgt[i*TGT_W +: TGT_W];
    end
  end
endmodule

// File: rtl/hcd_regs.sv
module hcd_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [4*DATA_W-1:0] arg_q,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] rv_q
);
  import hcd_pkg::*;

  logic [DATA_W-1:0] slot [REG_SLOTS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_SLOTS; i++) begin
      if (rst)                          slot[i] <= '0;
      else if (we && (sel == 3'(i)))    slot[i] <= wdata;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_arg
    assign arg_q[g*DATA_W +: DATA_W] = slot[g];
  end
  assign sp_q = slot[SLOT_SP];
  assign rv_q = slot[SLOT_RV];

  // R9
  regs_unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel > 3'd5) |=> ($stable(arg_q) && $stable(sp_q) && $stable(rv_q)));
endmodule

// File: rtl/hcd_ctrl.sv
module hcd_ctrl #(
  parameter int NUM_UNITS = 3,
  parameter int TGT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  localparam int ID_W     = $clog2(NUM_UNITS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_call,
  input  logic [TGT_W-1:0]           cpu_tgt,
  input  logic                       cpu_done,
  input  logic                       irq_ack,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_sel,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic [NUM_UNITS-1:0]       unit_call,
  input  logic [NUM_UNITS-1:0]       unit_to_sw,
  input  logic [NUM_UNITS*TGT_W-1:0] unit_tgt,
  input  logic [NUM_UNITS-1:0]       unit_finish,
  output logic [NUM_UNITS-1:0]       unit_en,
  output logic                       irq,
  output logic                       irq_swcall,
  output logic [TGT_W-1:0]           irq_swid,
  output logic [ID_W-1:0]            link_id,
  output logic [4*DATA_W-1:0]        arg_q,
  output logic [DATA_W-1:0]          sp_q,
  output logic [DATA_W-1:0]          rv_q,
  output logic                       err
);
  function automatic logic [NUM_UNITS-1:0] id_to_en(input logic [ID_W-1:0] id);
    logic [NUM_UNITS-1:0] v;
    for (int i = 0; i < NUM_UNITS; i++) v[i] = (id == ID_W'(i + 1));
    return v;
  endfunction

  logic [ID_W-1:0]  active_q, active_d;
  logic             s_call, s_sw, s_fin;
  logic [TGT_W-1:0] s_tgt;
  logic             push, pop, full, empty;
  logic [ID_W-1:0]  top;

  logic             cur_call, cur_sw, cur_fin, tgt_ok;
  logic [TGT_W-1:0] cur_tgt;
  logic             set_irq, irq_kind, set_err, lr_load;

  hcd_req_sel #(.N(NUM_UNITS), .TGT_W(TGT_W), .ID_W(ID_W)) i_sel (
    .active(active_q), .call(unit_call), .to_sw(unit_to_sw), .fin(unit_finish),
    .tgt(unit_tgt), .s_call(s_call), .s_sw(s_sw), .s_fin(s_fin), .s_tgt(s_tgt)
  );

  hcd_lifo #(.DEPTH(DEPTH), .W(ID_W)) i_ret (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(active_q),
    .top(top), .full(full), .empty(empty)
  );

  hcd_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .arg_q(arg_q), .sp_q(sp_q), .rv_q(rv_q)
  );

  // the owner of execution is the only source of requests
  always_comb begin
    if (active_q == '0) begin
      cur_call = cpu_call;
      cur_sw   = 1'b0;
      cur_tgt  = cpu_tgt;
      cur_fin  = cpu_done;
    end else begin
      cur_call = s_call;
      cur_sw   = s_sw;
      cur_tgt  = s_tgt;
      cur_fin  = s_fin;
    end
    tgt_ok = (cur_tgt != '0) && ({1'b0, cur_tgt} <= (TGT_W+1)'(NUM_UNITS));
  end

  always_comb begin
    push     = 1'b0;
    pop      = 1'b0;
    active_d = active_q;
    set_irq  = 1'b0;
    irq_kind = 1'b0;
    set_err  = 1'b0;
    lr_load  = 1'b0;
    if (cur_call) begin
      if (full || (!cur_sw && !tgt_ok)) begin
        set_err = 1'b1;
      end else begin
        push    = 1'b1;
        lr_load = 1'b1;
        if (cur_sw) begin
          active_d = '0;
          set_irq  = 1'b1;
          irq_kind = 1'b1;
        end else begin
          active_d = ID_W'(cur_tgt);
        end
      end
    end else if (cur_fin) begin
      if (empty) begin
        set_err = 1'b1;
      end else begin
        pop      = 1'b1;
        active_d = top;
        if (top == '0 && active_q != '0) set_irq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= '0;
      unit_en    <= '0;
      irq        <= 1'b0;
      irq_swcall <= 1'b0;
      irq_swid   <= '0;
      link_id    <= '0;
      err        <= 1'b0;
    end else begin
      active_q <= active_d;
      unit_en  <= id_to_en(active_d);
      if (lr_load) link_id <= active_q;
      if (set_err) err <= 1'b1;
      if (set_irq) begin
        irq        <= 1'b1;
        irq_swcall <= irq_kind;
        if (irq_kind) irq_swid <= cur_tgt;
      end else if (irq_ack) begin
        irq <= 1'b0;
      end
    end
  end

  // R3
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(unit_en));
  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> (unit_en == '0));
  // R2
  cpu_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0 && cpu_call && tgt_ok && !full) |=> (unit_en == id_to_en($past(cpu_tgt[ID_W-1:0]))));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
endmodule

// File: tb/test_hcd_ctrl.sv
module test_hcd_ctrl;
  localparam int N = 3, TW = 4, DW = 32, DEPTH = 4, IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_call, cpu_done, irq_ack, reg_we;
  logic [TW-1:0] cpu_tgt;
  logic [2:0] reg_sel;
  logic [DW-1:0] reg_wdata;
  logic [N-1:0] unit_call, unit_to_sw, unit_finish, unit_en;
  logic [N*TW-1:0] unit_tgt;
  logic irq, irq_swcall, err;
  logic [TW-1:0] irq_swid;
  logic [IW-1:0] link_id;
  logic [4*DW-1:0] arg_q;
  logic [DW-1:0] sp_q, rv_q;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hcd_ctrl #(.NUM_UNITS(N), .TGT_W(TW), .DATA_W(DW), .DEPTH(DEPTH)) i_hcd_ctrl (
    .clk(clk), .rst(rst), .cpu_call(cpu_call), .cpu_tgt(cpu_tgt), .cpu_done(cpu_done),
    .irq_ack(irq_ack), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .unit_call(unit_call), .unit_to_sw(unit_to_sw), .unit_tgt(unit_tgt),
    .unit_finish(unit_finish), .unit_en(unit_en), .irq(irq), .irq_swcall(irq_swcall),
    .irq_swid(irq_swid), .link_id(link_id), .arg_q(arg_q), .sp_q(sp_q), .rv_q(rv_q),
    .err(err)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_call = 0; cpu_done = 0; irq_ack = 0; reg_we = 0; cpu_tgt = '0;
    reg_sel = '0; reg_wdata = '0; unit_call = '0; unit_to_sw = '0;
    unit_tgt = '0; unit_finish = '0;
  endtask

  task automatic do_reset();
    rst = 1; idle(); cyc(); cyc(); rst = 0;
  endtask

  task automatic c_call(int t);
    cpu_call = 1; cpu_tgt = TW'(t); cyc(); idle();
  endtask

  task automatic c_done();
    cpu_done = 1; cyc(); idle();
  endtask

  task automatic ack();
    irq_ack = 1; cyc(); idle();
  endtask

  task automatic u_call(int k, int t, bit sw);
    unit_call[k-1] = 1; unit_to_sw[k-1] = sw; unit_tgt[(k-1)*TW +: TW] = TW'(t);
    cyc(); idle();
  endtask

  task automatic u_fin(int k);
    unit_finish[k-1] = 1; cyc(); idle();
  endtask

  task automatic wr(int s, logic [DW-1:0] v);
    reg_we = 1; reg_sel = 3'(s); reg_wdata = v; cyc(); idle();
  endtask

  task automatic t_reset();
    check("R1 en", 64'(unit_en), 0);
    check("R1 irq", 64'(irq), 0);
    check("R1 cause", 64'(irq_swcall), 0);
    check("R1 err", 64'(err), 0);
    check("R1 link", 64'(link_id), 0);
    check("R1 args", 64'(arg_q[63:0] | arg_q[127:64]), 0);
    check("R1 sp/rv", 64'(sp_q | rv_q), 0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 6; i++) wr(i, 32'h11 * (i + 1));
    for (int i = 0; i < 4; i++) check("R9 arg", 64'(arg_q[i*DW +: DW]), 64'(32'h11 * (i + 1)));
    check("R9 sp", 64'(sp_q), 64'h55);
    check("R9 rv", 64'(rv_q), 64'h66);
    wr(6, 32'hffff_ffff);
    wr(7, 32'hffff_ffff);
    check("R9 unused code args", 64'(arg_q[63:0]), 64'h0000_0022_0000_0011);
    check("R9 unused code args hi", 64'(arg_q[127:64]), 64'h0000_0044_0000_0033);
    check("R9 unused code sp/rv", {sp_q, rv_q}, 64'h0000_0055_0000_0066);
  endtask

  task automatic t_sw_calls_hw();
    c_call(2);
    check("R2 enable", 64'(unit_en), 64'b010);
    check("R2 link", 64'(link_id), 0);
    u_call(1, 3, 0);
    check("R3 foreign call", 64'(unit_en), 64'b010);
    u_fin(3);
    check("R3 foreign finish", 64'(unit_en), 64'b010);
    c_call(3);
    check("R12 cpu call ignored", 64'(unit_en), 64'b010);
    c_done();
    check("R12 cpu done ignored", 64'(unit_en), 64'b010);
    check("R12 no err", 64'(err), 0);
    u_fin(2);
    check("R4 en off", 64'(unit_en), 0);
    check("R4 irq", 64'(irq), 1);
    check("R4 cause", 64'(irq_swcall), 0);
    ack();
    check("R4 ack", 64'(irq), 0);
  endtask

  task automatic t_hw_calls_sw();
    c_call(1);
    u_call(1, 9, 1);
    check("R5 en off", 64'(unit_en), 0);
    check("R5 irq", 64'(irq), 1);
    check("R5 cause", 64'(irq_swcall), 1);
    check("R5 swid", 64'(irq_swid), 9);
    check("R5 link", 64'(link_id), 1);
    ack();
    c_done();
    check("R6 resume", 64'(unit_en), 64'b001);
    check("R6 no irq", 64'(irq), 0);
    u_fin(1);
    check("R4 return to cpu", 64'(irq), 1);
    ack();
  endtask

  task automatic t_hw_hw();
    c_call(1);
    u_call(1, 3, 0);
    check("R7 callee", 64'(unit_en), 64'b100);
    check("R7 link", 64'(link_id), 1);
    u_fin(3);
    check("R7 caller back", 64'(unit_en), 64'b001);
    check("R7 no irq", 64'(irq), 0);
    u_fin(1);
    check("R7 final irq", 64'(irq), 1);
    ack();
  endtask

  task automatic t_recursion();
    c_call(2);
    u_call(2, 2, 0);
    check("R8 self en", 64'(unit_en), 64'b010);
    check("R8 self link", 64'(link_id), 2);
    u_fin(2);
    check("R8 first pop", 64'(unit_en), 64'b010);
    check("R8 first pop irq", 64'(irq), 0);
    u_fin(2);
    check("R8 second pop en", 64'(unit_en), 0);
    check("R8 second pop irq", 64'(irq), 1);
    ack();
  endtask

  task automatic t_errors();
    do_reset();
    c_done();
    check("R11 underflow err", 64'(err), 1);
    check("R11 underflow en", 64'(unit_en), 0);
    do_reset();
    c_call(0);
    check("R11 bad tgt 0", 64'(err), 1);
    do_reset();
    c_call(1);
    u_call(1, 5, 0);
    check("R11 bad tgt high err", 64'(err), 1);
    check("R11 bad tgt high en", 64'(unit_en), 64'b001);
  endtask

  task automatic t_overflow();
    do_reset();
    c_call(1);
    u_call(1, 2, 0);
    u_call(2, 1, 0);
    u_call(1, 2, 0);
    check("R10 full no err", 64'(err), 0);
    u_call(2, 1, 0);
    check("R10 overflow err", 64'(err), 1);
    check("R10 overflow en", 64'(unit_en), 64'b010);
    u_fin(2);
    check("R10 unwind 1", 64'(unit_en), 64'b001);
    u_fin(1);
    check("R10 unwind 2", 64'(unit_en), 64'b010);
    u_fin(2);
    check("R10 unwind 3", 64'(unit_en), 64'b001);
    u_fin(1);
    check("R10 unwind irq", 64'(irq), 1);
    check("R10 sticky", 64'(err), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    do_reset();
    t_reset();
    t_regs();
    t_sw_calls_hw();
    t_hw_calls_sw();
    t_hw_hw();
    t_recursion();
    t_errors();
    t_overflow();
    summary();
  end
endmodule